// File: doc/BRIEF.md
# PFC Controller Operating-Mode Sequencer

This block is the mode controller of a power-factor-correction stage. It takes eleven one-bit comparator flags from the analog front end and decides, once per clock, whether the converter sleeps, idles in stand-by with its bias alive, ramps up in soft-start, runs normally, or is held off by an overvoltage or a peak-current event. It drives a gate-drive enable for the PWM stage, a request to discharge the compensation node, an internal bias enable and a three-bit state code.

Every flag is asynchronous to the controller clock. Each one passes through a two-flop synchronizer, and the state register then adds one more edge. The gate enable is decoded from both the current state and the next state. It therefore drops in the same cycle that a synchronized fault flag first appears, one edge before the state code shows the new mode. All pins are plain control and status levels. No pin carries a data stream, so there is no valid/ready handshake.

Top module: `pfc_mode_seq`

## Requirements
- R1: After reset the state code is 0 (sleep) and gate enable, bias enable and discharge request are all low. The state codes are 0 sleep, 1 stand-by, 2 soft-start, 3 normal, 4 overvoltage hold, 5 peak-current limit.
- R2: In sleep or stand-by, a low turn-on flag (`vcc_on_i`) forces sleep. In soft-start, normal, overvoltage hold and peak limit, only a low undervoltage flag (`vcc_uv_ok_i`) forces sleep. The change takes effect with no discharge phase. In sleep, bias enable and gate enable are low.
- R3: A high sleep request moves to sleep at once if `comp_low_i` is high, and also when the block is already asleep. Otherwise the block goes to, or stays in, stand-by and asserts the discharge request until `comp_low_i` rises. It then enters sleep.
- R4: When no undervoltage or sleep condition is active, an open-loop flag or a brown-out forces stand-by from any state. In stand-by, bias enable is high and gate enable is low.
- R5: In sleep or stand-by, brown-out means `bo_start_ok_i` is low. In the four running states, brown-out means `bo_run_ok_i` is low, and a low `bo_start_ok_i` alone has no effect there.
- R6: On entry to stand-by from any running state, the discharge request is high while `comp_low_i` is low. It falls when `comp_low_i` rises. Stand-by entered from sleep does not discharge.
- R7: From sleep or stand-by, soft-start begins only when the supply is above turn-on, there is no open loop, no brown-out and no sleep request, and `comp_low_i` is high. A pre-biased compensation node (`comp_low_i` low) keeps the block where it is.
- R8: Soft-start moves to normal when `comp_full_i` is high. Gate enable is high in soft-start and normal, and low in every other state.
- R9: From soft-start, normal or peak limit, a high `ovp_set_i` enters overvoltage hold. The hold is left only when `ovp_clr_i` is high and `ovp_set_i` is low.
- R10: From soft-start or normal, a high `ipk_trip_i` enters peak limit. The block leaves peak limit when the trip flag falls.
- R11: Priority, highest first, is undervoltage/sleep, then stand-by, then overvoltage, then peak limit, then the normal progression. On leaving overvoltage hold, a still-high trip flag leads to peak limit. Otherwise, and on leaving peak limit, the block returns to the soft-start or normal state held before the fault.
- R12: Every flag is seen through two flip-flops. A change applied before clock edge k reaches gate enable and the discharge request after edge k+1, and reaches the state code after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_on_i | input | 1 | Supply above the turn-on level |
| vcc_uv_ok_i | input | 1 | Supply above the undervoltage level |
| sleep_req_i | input | 1 | Enable pin requests sleep |
| bo_start_ok_i | input | 1 | Line sense above the start brown-out level |
| bo_run_ok_i | input | 1 | Line sense above the run brown-out level |
| open_loop_i | input | 1 | Feedback below the open-loop level |
| comp_low_i | input | 1 | Compensation node below the start level |
| comp_full_i | input | 1 | Compensation node has swept its full range |
| ovp_set_i | input | 1 | Output above the overvoltage level |
| ovp_clr_i | input | 1 | Output below the overvoltage reset level |
| ipk_trip_i | input | 1 | Current sense above the peak limit |
| gate_en_o | output | 1 | Gate drive may switch |
| comp_dis_o | output | 1 | Discharge the compensation node |
| bias_en_o | output | 1 | Internal bias enable |
| state_o | output | 3 | Current mode code |

## Verification
The overvoltage-set flag and the peak-current trip can become valid in the same synchronized cycle. The overvoltage release can also coincide with a trip that is still active. A directed case raises both flags together while the block runs normally, then clears the overvoltage while the trip is held, then clears the trip. The bench expects hold, then peak limit, then a return to normal. The random phase keeps both fault flags frequent, so these collisions also occur against sleep requests and brown-outs. Every cycle is compared with a reference model that the bench computes from the priority rules.

// File: rtl/pfc_mode_pkg.sv
package pfc_mode_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP = 3'd0,
    ST_STBY  = 3'd1,
    ST_SOFT  = 3'd2,
    ST_NORM  = 3'd3,
    ST_OVH   = 3'd4,
    ST_IPK   = 3'd5
  } mode_e;

  localparam int FLAG_W    = 11;
  localparam int F_VCC_ON  = 0;
  localparam int F_UV_OK   = 1;
  localparam int F_SLEEP   = 2;
  localparam int F_BO_ST   = 3;
  localparam int F_BO_RUN  = 4;
  localparam int F_OPEN    = 5;
  localparam int F_CLOW    = 6;
  localparam int F_CFULL   = 7;
  localparam int F_OV_SET  = 8;
  localparam int F_OV_CLR  = 9;
  localparam int F_IPK     = 10;

  function automatic logic is_running(input mode_e s);
    return (s == ST_SOFT) || (s == ST_NORM) || (s == ST_OVH) || (s == ST_IPK);
  endfunction

  function automatic logic is_driving(input mode_e s);
    return (s == ST_SOFT) || (s == ST_NORM);
  endfunction
endpackage

// File: rtl/pfc_flag_sync.sv
module pfc_flag_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/pfc_mode_fsm.sv
module pfc_mode_fsm
  import pfc_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] f,
  output mode_e             state_q,
  output mode_e             nxt,
  output logic              dis_q
);
  mode_e ret_q;
  logic  run_now, uv_hit, bo_hit, sb_hit, dis_d;

  always_comb begin
    run_now = is_running(state_q);
    uv_hit  = run_now ? !f[F_UV_OK]  : !f[F_VCC_ON];
    bo_hit  = run_now ? !f[F_BO_RUN] : !f[F_BO_ST];
    sb_hit  = f[F_OPEN] || bo_hit;
    nxt     = state_q;
    if (uv_hit) begin
      nxt = ST_SLEEP;
    end else if (f[F_SLEEP]) begin
      nxt = (f[F_CLOW] || state_q == ST_SLEEP) ? ST_SLEEP : ST_STBY;
    end else if (sb_hit) begin
      nxt = ST_STBY;
    end else begin
      case (state_q)
        ST_SLEEP, ST_STBY: if (f[F_CLOW]) nxt = ST_SOFT;
        ST_SOFT: begin
          if (f[F_OV_SET])     nxt = ST_OVH;
          else if (f[F_IPK])   nxt = ST_IPK;
          else if (f[F_CFULL]) nxt = ST_NORM;
        end
        ST_NORM: begin
          if (f[F_OV_SET])   nxt = ST_OVH;
          else if (f[F_IPK]) nxt = ST_IPK;
        end
        ST_OVH: if (f[F_OV_CLR] && !f[F_OV_SET]) nxt = f[F_IPK] ? ST_IPK : ret_q;
        ST_IPK: begin
          if (f[F_OV_SET])   nxt = ST_OVH;
          else if (!f[F_IPK]) nxt = ret_q;
        end
        default: nxt = ST_SLEEP;
      endcase
    end
  end

  always_comb begin
    dis_d = 1'b0;
    if (nxt == ST_STBY && !f[F_CLOW]) begin
      if (run_now || f[F_SLEEP] || dis_q) dis_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SLEEP;
      ret_q   <= ST_SOFT;
      dis_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      dis_q   <= dis_d;
      if (is_driving(state_q) && (nxt == ST_OVH || nxt == ST_IPK)) ret_q <= state_q;
    end
  end

  AST_UV_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    is_running(state_q) && !f[F_UV_OK] |=> state_q == ST_SLEEP) else $error("uv"); // R2
  AST_PREBIAS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP || state_q == ST_STBY) && !f[F_CLOW] |=> state_q != ST_SOFT) else $error("prebias"); // R7
  AST_OVH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_OVH && !f[F_OV_CLR] && !uv_hit && !f[F_SLEEP] && !sb_hit |=> state_q == ST_OVH) else $error("ovh"); // R9
  AST_IPK_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IPK && !f[F_IPK] && !f[F_OV_SET] && !uv_hit && !f[F_SLEEP] && !sb_hit
    |=> is_driving(state_q) && state_q == $past(ret_q)) else $error("ipk"); // R10
  AST_RET_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    is_driving(ret_q)) else $error("ret"); // R11
  AST_NO_DIRECT_SLEEP_START: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_SLEEP && !f[F_VCC_ON] |=> state_q == ST_SLEEP) else $error("turn-on"); // R2
endmodule

// File: rtl/pfc_mode_outdec.sv
module pfc_mode_outdec
  import pfc_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e state_q,
  input  mode_e nxt,
  input  logic  dis_q,
  input  logic  comp_low,
  output logic  gate_en,
  output logic  comp_dis,
  output logic  bias_en
);
  assign gate_en  = is_driving(state_q) && is_driving(nxt);
  assign bias_en  = (state_q != ST_SLEEP);
  assign comp_dis = (state_q == ST_STBY) && dis_q && !comp_low;

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_SLEEP |-> !gate_en && !comp_dis) else $error("sleep out"); // R2
  AST_FAULT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en |=> is_driving(state_q)) else $error("gate"); // R8
endmodule

// File: rtl/pfc_mode_seq.sv
module pfc_mode_seq
  import pfc_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_on_i,
  input  logic       vcc_uv_ok_i,
  input  logic       sleep_req_i,
  input  logic       bo_start_ok_i,
  input  logic       bo_run_ok_i,
  input  logic       open_loop_i,
  input  logic       comp_low_i,
  input  logic       comp_full_i,
  input  logic       ovp_set_i,
  input  logic       ovp_clr_i,
  input  logic       ipk_trip_i,
  output logic       gate_en_o,
  output logic       comp_dis_o,
  output logic       bias_en_o,
  output logic [2:0] state_o
);
  logic [FLAG_W-1:0] raw, syn;
  mode_e             state_q, nxt;
  logic              dis_q;

  assign raw = {ipk_trip_i, ovp_clr_i, ovp_set_i, comp_full_i, comp_low_i, open_loop_i,
                bo_run_ok_i, bo_start_ok_i, sleep_req_i, vcc_uv_ok_i, vcc_on_i};

  pfc_flag_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  pfc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .f(syn), .state_q(state_q), .nxt(nxt), .dis_q(dis_q)
  );

  pfc_mode_outdec u_out (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .nxt(nxt), .dis_q(dis_q),
    .comp_low(syn[F_CLOW]), .gate_en(gate_en_o), .comp_dis(comp_dis_o), .bias_en(bias_en_o)
  );

  assign state_o = state_q;
endmodule

// File: tb/test_pfc_mode_seq.sv
module test_pfc_mode_seq;
  localparam int VON = 0, UVOK = 1, SLP = 2, BOS = 3, BOR = 4, OL = 5,
                 CLO = 6, CFU = 7, OVS = 8, OVC = 9, IPK = 10;
  localparam int SLEEP = 0, STBY = 1, SOFT = 2, NORM = 3, OVH = 4, LIM = 5;

  logic clk = 0, rst_n = 0;
  logic [10:0] vin = '0;
  logic gate, dis, bias;
  logic [2:0] st;
  int checks = 0, fails = 0;

  // reference model
  logic [10:0] m_s1 = '0, m_s2 = '0;
  int m_st = SLEEP, m_ret = SOFT;
  bit m_dis = 0;

  always #5 clk = ~clk;

  pfc_mode_seq i_pfc_mode_seq (
    .clk(clk), .rst_n(rst_n),
    .vcc_on_i(vin[VON]), .vcc_uv_ok_i(vin[UVOK]), .sleep_req_i(vin[SLP]),
    .bo_start_ok_i(vin[BOS]), .bo_run_ok_i(vin[BOR]), .open_loop_i(vin[OL]),
    .comp_low_i(vin[CLO]), .comp_full_i(vin[CFU]), .ovp_set_i(vin[OVS]),
    .ovp_clr_i(vin[OVC]), .ipk_trip_i(vin[IPK]),
    .gate_en_o(gate), .comp_dis_o(dis), .bias_en_o(bias), .state_o(st)
  );

  function automatic bit running(int s);
    return s == SOFT || s == NORM || s == OVH || s == LIM;
  endfunction

  function automatic int ref_next(int s, logic [10:0] f, int r);
    bit run = running(s);
    if (run ? !f[UVOK] : !f[VON]) return SLEEP;
    if (f[SLP]) return (f[CLO] || s == SLEEP) ? SLEEP : STBY;
    if (f[OL] || (run ? !f[BOR] : !f[BOS])) return STBY;
    case (s)
      SLEEP, STBY: return f[CLO] ? SOFT : s;
      SOFT: return f[OVS] ? OVH : f[IPK] ? LIM : f[CFU] ? NORM : SOFT;
      NORM: return f[OVS] ? OVH : f[IPK] ? LIM : NORM;
      OVH:  return (f[OVC] && !f[OVS]) ? (f[IPK] ? LIM : r) : OVH;
      default: return f[OVS] ? OVH : !f[IPK] ? r : LIM;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    int n;
    bit d;
    @(posedge clk);
    @(negedge clk);
    n = ref_next(m_st, m_s2, m_ret);
    d = (n == STBY) && !m_s2[CLO] && (running(m_st) || m_s2[SLP] || m_dis);
    if ((m_st == SOFT || m_st == NORM) && (n == OVH || n == LIM)) m_ret = m_st;
    m_st = n; m_dis = d;
    m_s2 = m_s1; m_s1 = vin;
    n = ref_next(m_st, m_s2, m_ret);
    chk(tag, "state", int'(st), m_st);
    chk(tag, "gate", int'(gate), int'((m_st == SOFT || m_st == NORM) && (n == SOFT || n == NORM)));
    chk(tag, "bias", int'(bias), int'(m_st != SLEEP));
    chk(tag, "dis", int'(dis), int'(m_st == STBY && m_dis && !m_s2[CLO]));
  endtask

  task automatic apply(logic [10:0] v, int n, string tag);
    vin = v;
    for (int i = 0; i < n; i++) step(tag);
  endtask

  localparam logic [10:0] GOOD = (11'd1 << VON) | (11'd1 << UVOK) | (11'd1 << BOS) |
                                 (11'd1 << BOR) | (11'd1 << CLO) | (11'd1 << OVC);

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [10:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset state", int'(st), SLEEP);
    chk("R1", "reset gate", int'(gate), 0);
    chk("R1", "reset bias", int'(bias), 0);
    rst_n = 1;
    apply('0, 3, "R1");

    // R7: pre-bias blocks start
    apply(GOOD & ~(11'd1 << CLO), 8, "R7");
    chk("R7", "prebias hold", int'(st), SLEEP);
    apply(GOOD, 4, "R7");
    chk("R7", "start", int'(st), SOFT);
    // R8
    apply(GOOD | (11'd1 << CFU), 4, "R8");
    chk("R8", "normal", int'(st), NORM);
    chk("R8", "gate on", int'(gate), 1);
    // R12 latency / R10
    vin = GOOD | (11'd1 << IPK);
    step("R12"); chk("R12", "gate after 1 edge", int'(gate), 1);
    step("R12"); chk("R12", "gate after 2 edges", int'(gate), 0);
    chk("R12", "state lags", int'(st), NORM);
    step("R12"); chk("R10", "limit", int'(st), LIM);
    apply(GOOD, 4, "R10");
    chk("R10", "limit exit", int'(st), NORM);
    // R9
    apply((GOOD & ~(11'd1 << OVC)) | (11'd1 << OVS), 4, "R9");
    chk("R9", "ovh", int'(st), OVH);
    apply(GOOD & ~(11'd1 << OVC), 5, "R9");
    chk("R9", "ovh held", int'(st), OVH);
    apply(GOOD, 4, "R9");
    chk("R9", "ovh exit", int'(st), NORM);
    // R11: simultaneous faults
    apply((GOOD & ~(11'd1 << OVC)) | (11'd1 << OVS) | (11'd1 << IPK), 4, "R11");
    chk("R11", "ovp wins", int'(st), OVH);
    apply(GOOD | (11'd1 << IPK), 4, "R11");
    chk("R11", "to limit", int'(st), LIM);
    apply(GOOD, 4, "R11");
    chk("R11", "return normal", int'(st), NORM);
    // R5 brown-out thresholds
    apply(GOOD & ~(11'd1 << BOS), 5, "R5");
    chk("R5", "start lvl ignored", int'(st), NORM);
    apply(GOOD & ~(11'd1 << BOS) & ~(11'd1 << BOR) & ~(11'd1 << CLO), 4, "R5");
    chk("R5", "run brownout", int'(st), STBY);
    // R6 discharge after run
    chk("R6", "discharge", int'(dis), 1);
    chk("R4", "bias stby", int'(bias), 1);
    apply(GOOD & ~(11'd1 << BOS) & ~(11'd1 << BOR), 3, "R6");
    chk("R6", "discharge off", int'(dis), 0);
    apply(GOOD & ~(11'd1 << BOS), 3, "R5");
    chk("R5", "start blocked", int'(st), STBY);
    apply(GOOD, 4, "R7");
    chk("R7", "restart", int'(st), SOFT);
    // R4 open loop
    apply(GOOD | (11'd1 << OL), 4, "R4");
    chk("R4", "open loop", int'(st), STBY);
    chk("R4", "gate off", int'(gate), 0);
    // R3 sleep request with pre-bias
    apply(GOOD, 4, "R3");
    apply((GOOD | (11'd1 << SLP)) & ~(11'd1 << CLO), 5, "R3");
    chk("R3", "pending sleep", int'(st), STBY);
    chk("R3", "pending dis", int'(dis), 1);
    apply(GOOD | (11'd1 << SLP), 4, "R3");
    chk("R3", "sleep", int'(st), SLEEP);
    // R2 undervoltage
    apply(GOOD | (11'd1 << CFU), 6, "R2");
    apply((GOOD | (11'd1 << CFU)) & ~(11'd1 << VON), 5, "R2");
    chk("R2", "uv run level", int'(st), NORM);
    apply(GOOD & ~(11'd1 << VON) & ~(11'd1 << UVOK), 4, "R2");
    chk("R2", "uv sleep", int'(st), SLEEP);
    chk("R2", "bias off", int'(bias), 0);

    // R12 random: full model compare
    void'($urandom(32'h5eed));
    for (int k = 0; k < 2500; k++) begin
      v = '0;
      v[VON]  = ($urandom % 100) < 95;
      v[UVOK] = v[VON] || (($urandom % 100) < 70);
      v[SLP]  = ($urandom % 100) < 5;
      v[BOS]  = ($urandom % 100) < 90;
      v[BOR]  = v[BOS] || (($urandom % 100) < 70);
      v[OL]   = ($urandom % 100) < 4;
      v[CLO]  = ($urandom % 100) < 55;
      v[CFU]  = ($urandom % 100) < 30;
      v[OVS]  = ($urandom % 100) < 10;
      v[OVC]  = !v[OVS] && (($urandom % 100) < 70);
      v[IPK]  = ($urandom % 100) < 12;
      apply(v, 1 + ($urandom % 6), "R12");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule